// File: doc/BRIEF.md
# Delayed Register Write Queue

This block holds register writes back for a programmable number of ticks before they land in a small internal register file. It models hazard-delayed state updates, such as a status bit or a coprocessor register that only takes its new value a few pipeline steps after the instruction that produced it. Each queued write names:

- a destination register;
- a delay;
- an operand width of 32 or 64 bits;
- a value;
- an optional bit position.

With a bit position, the write sets or clears that single bit. Without one, it replaces the register.

The queue is a ring of `SLOTS` entries. Every pulse on the tick input counts down each pending entry's delay. An entry performs its write on the tick that brings its delay to zero, even if it is not the oldest entry. A slot is only released once every older entry has also completed, so slots leave the ring strictly in arrival order. The register file is read through a combinational read port. A sticky error flag reports an inconsistent ring state.

Top module: `dq_delay_queue`

## Requirements
- R1: After reset, every register reads zero, `full_o` is 0 and `err_o` is 0.
- R2: An enqueue while the queue holds fewer than `SLOTS` entries is accepted and adds one entry. `full_o` is 1 exactly when `SLOTS` entries are held.
- R3: An enqueue presented while `full_o` is 1 is dropped: its write never reaches the register file.
- R4: Each tick lowers every pending entry's delay by one. The write becomes visible on `rd_data_o` right after the tick that brings the delay to zero, and not before. A requested delay of 0 behaves as a delay of 1. No register changes without a tick.
- R5: A whole-value write (`enq_bit_en_i`=0) with `enq_wide_i`=1 replaces all 64 bits. With `enq_wide_i`=0 it replaces bits 31:0 and keeps bits 63:32.
- R6: A single-bit write (`enq_bit_en_i`=1) sets the addressed bit when the value is nonzero and clears it when the value is zero, leaving all other bits unchanged. For `enq_wide_i`=1 the position is `enq_bit_i[5:0]` and the value test covers 64 bits. For `enq_wide_i`=0 the position is `enq_bit_i[4:0]` and the value test covers bits 31:0 only.
- R7: An entry behind an older, still pending entry performs its write when its own delay expires. Its slot stays occupied until every older entry has completed. Slots are only released on a tick.
- R8: Each entry performs its write exactly once. A completed entry waiting behind the head is neither counted down nor written again.
- R9: When several entries complete on the same tick, their writes take effect in queue order, so for a shared register the newest entry's value remains.
- R10: An enqueue presented in the same cycle as a tick is not counted down by that tick.
- R11: `err_o` becomes 1, and stays 1, if the write and release pointers disagree while the queue is empty. It stays 0 in all legal operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enq_valid_i | input | 1 | Enqueue a write this cycle |
| enq_reg_i | input | 2 | Destination register index |
| enq_delay_i | input | 4 | Ticks before the write applies (0 acts as 1) |
| enq_wide_i | input | 1 | 1: 64-bit operand, 0: 32-bit operand |
| enq_bit_en_i | input | 1 | 1: single-bit set/clear, 0: whole-value write |
| enq_bit_i | input | 6 | Bit position for single-bit writes |
| enq_value_i | input | 64 | Write value, or set/clear selector |
| tick_i | input | 1 | Count down all pending entries |
| full_o | output | 1 | Queue holds SLOTS entries; enqueues are dropped |
| rd_addr_i | input | 2 | Register file read index |
| rd_data_o | output | 64 | Register file read data (combinational) |
| err_o | output | 1 | Sticky pointer-mismatch error |

## Verification
The checker watches the following every cycle:

- occupancy stays within the ring size;
- an accepted enqueue adds exactly one entry when no tick is present;
- a dropped enqueue leaves occupancy unchanged;
- a cycle without a tick neither releases slots nor changes a register;
- the mismatch flag stays clear.

Only the bench scenarios can show the write semantics themselves: how 32- and 64-bit operands are merged, bit set against bit clear, the exact tick on which a write lands, and delay 0 acting as 1. The same holds for out-of-order completion behind a long head entry, exactly-once application, ordering of writes that complete on the same tick, and an enqueue that coincides with a tick.

// File: rtl/dq_pkg.sv
package dq_pkg;

    localparam int DATA_W    = 64;
    localparam int HALF_W    = DATA_W / 2;
    localparam int REG_IDX_W = 2;
    localparam int NREGS     = 1 << REG_IDX_W;
    localparam int DLY_W     = 4;
    localparam int BIT_W     = $clog2(DATA_W);

    typedef struct packed {
        logic [REG_IDX_W-1:0] dst;
        logic                 wide;
        logic                 bit_en;
        logic [BIT_W-1:0]     bitpos;
        logic [DATA_W-1:0]    val;
    } wr_cmd_t;

    typedef struct packed {
        wr_cmd_t          cmd;
        logic [DLY_W-1:0] dly;
        logic             busy;
        logic             done;
    } slot_t;

    // Merge one write command into the current register contents.
    function automatic logic [DATA_W-1:0] dq_merge(logic [DATA_W-1:0] cur, wr_cmd_t c);
        logic [BIT_W-1:0]  pos;
        logic [DATA_W-1:0] mask;
        logic              nz;
        pos  = c.wide ? c.bitpos : {1'b0, c.bitpos[BIT_W-2:0]};
        mask = {{(DATA_W-1){1'b0}}, 1'b1} << pos;
        nz   = c.wide ? (c.val != '0) : (c.val[HALF_W-1:0] != '0);
        if (c.bit_en)
            return nz ? (cur | mask) : (cur & ~mask);
        else if (c.wide)
            return c.val;
        else
            return {cur[DATA_W-1:HALF_W], c.val[HALF_W-1:0]};
    endfunction

endpackage

// File: rtl/dq_ring.sv
module dq_ring
    import dq_pkg::*;
#(
    parameter int SLOTS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enq_valid,
    input  wr_cmd_t              enq_cmd,
    input  logic [DLY_W-1:0]     enq_dly,
    input  logic                 tick,
    output wr_cmd_t [SLOTS-1:0]  ord_cmd,
    output logic [SLOTS-1:0]     ord_fire,
    output logic [$clog2(SLOTS+1)-1:0] count,
    output logic                 err
);

    localparam int PW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int CW = $clog2(SLOTS + 1);

    typedef struct packed {
        slot_t [SLOTS-1:0] slot;
        logic [PW-1:0]     inp;
        logic [PW-1:0]     outp;
        logic [CW-1:0]     cnt;
        logic              err;
    } ring_t;

    ring_t q, d;

    function automatic logic [PW-1:0] wrap(logic [PW-1:0] base, int k);
        int s;
        s = int'(base) + k;
        if (s >= SLOTS) s = s - SLOTS;
        return PW'(s);
    endfunction

    always_comb begin
        logic [PW-1:0] idx;
        int            pops;
        logic          stop;
        d        = q;
        ord_cmd  = '0;
        ord_fire = '0;
        pops     = 0;
        stop     = 1'b0;
        idx      = '0;

        // Count down pending entries in queue order, flag those expiring.
        if (tick) begin
            for (int k = 0; k < SLOTS; k++) begin
                idx = wrap(q.outp, k);
                if (CW'(k) < q.cnt && q.slot[idx].busy && !q.slot[idx].done) begin
                    d.slot[idx].dly = q.slot[idx].dly - 1'b1;
                    if (q.slot[idx].dly == DLY_W'(1)) begin
                        d.slot[idx].done = 1'b1;
                        ord_cmd[k]       = q.slot[idx].cmd;
                        ord_fire[k]      = 1'b1;
                    end
                end
            end
        end

        // Release the unbroken run of completed entries at the head.
        for (int k = 0; k < SLOTS; k++) begin
            idx = wrap(q.outp, k);
            if (!stop && CW'(k) < q.cnt && d.slot[idx].done) begin
                d.slot[idx].busy = 1'b0;
                d.slot[idx].done = 1'b0;
                pops             = pops + 1;
            end else begin
                stop = 1'b1;
            end
        end
        d.outp = wrap(q.outp, pops);
        d.cnt  = q.cnt - CW'(pops);

        // Accept a new entry into the free slot at the write pointer.
        if (enq_valid && q.cnt != CW'(SLOTS)) begin
            d.slot[q.inp].cmd  = enq_cmd;
            d.slot[q.inp].dly  = (enq_dly == '0) ? DLY_W'(1) : enq_dly;
            d.slot[q.inp].busy = 1'b1;
            d.slot[q.inp].done = 1'b0;
            d.inp              = wrap(q.inp, 1);
            d.cnt              = d.cnt + 1'b1;
        end

        if (q.inp != q.outp && q.cnt == '0)
            d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign count = q.cnt;
    assign err   = q.err;

endmodule

// File: rtl/dq_regfile.sv
module dq_regfile
    import dq_pkg::*;
#(
    parameter int SLOTS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  wr_cmd_t [SLOTS-1:0]   ord_cmd,
    input  logic [SLOTS-1:0]      ord_fire,
    input  logic [REG_IDX_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]     rd_data
);

    logic [NREGS-1:0][DATA_W-1:0] regs_d, regs_q;

    // Apply expiring writes oldest first so the newest one wins.
    always_comb begin
        regs_d = regs_q;
        for (int k = 0; k < SLOTS; k++) begin
            if (ord_fire[k])
                regs_d[ord_cmd[k].dst] = dq_merge(regs_d[ord_cmd[k].dst], ord_cmd[k]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign rd_data = regs_q[rd_addr];

endmodule

// File: rtl/dq_delay_queue.sv
module dq_delay_queue
    import dq_pkg::*;
#(
    parameter int SLOTS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enq_valid_i,
    input  logic [REG_IDX_W-1:0] enq_reg_i,
    input  logic [DLY_W-1:0]     enq_delay_i,
    input  logic                 enq_wide_i,
    input  logic                 enq_bit_en_i,
    input  logic [BIT_W-1:0]     enq_bit_i,
    input  logic [DATA_W-1:0]    enq_value_i,
    input  logic                 tick_i,
    output logic                 full_o,
    input  logic [REG_IDX_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0]    rd_data_o,
    output logic                 err_o
);

    localparam int CW = $clog2(SLOTS + 1);

    wr_cmd_t               new_cmd;
    wr_cmd_t [SLOTS-1:0]   fire_cmd;
    logic [SLOTS-1:0]      fire_vec;
    logic [CW-1:0]         occ;

    always_comb begin
        new_cmd.dst    = enq_reg_i;
        new_cmd.wide   = enq_wide_i;
        new_cmd.bit_en = enq_bit_en_i;
        new_cmd.bitpos = enq_bit_i;
        new_cmd.val    = enq_value_i;
    end

    dq_ring #(.SLOTS(SLOTS)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .enq_valid (enq_valid_i),
        .enq_cmd   (new_cmd),
        .enq_dly   (enq_delay_i),
        .tick      (tick_i),
        .ord_cmd   (fire_cmd),
        .ord_fire  (fire_vec),
        .count     (occ),
        .err       (err_o)
    );

    dq_regfile #(.SLOTS(SLOTS)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .ord_cmd  (fire_cmd),
        .ord_fire (fire_vec),
        .rd_addr  (rd_addr_i),
        .rd_data  (rd_data_o)
    );

    assign full_o = (occ == CW'(SLOTS));

endmodule

// File: rtl/dq_delay_queue_chk.sv
module dq_delay_queue_chk
    import dq_pkg::*;
#(
    parameter int SLOTS = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          enq_valid_i,
    input logic                          tick_i,
    input logic                          full_o,
    input logic [$clog2(SLOTS+1)-1:0]    occ,
    input logic [REG_IDX_W-1:0]          rd_addr_i,
    input logic [DATA_W-1:0]             rd_data_o,
    input logic                          err_o
);

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ) <= SLOTS); // R2

    AST_ENQ_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid_i && !full_o && !tick_i) |=> (int'(occ) == int'($past(occ)) + 1)); // R2

    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid_i && full_o && !tick_i) |=> (occ == $past(occ))); // R3

    AST_NO_TICK_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tick_i) && $stable(rd_addr_i)) |-> $stable(rd_data_o)); // R4

    AST_NO_TICK_NO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> (occ >= $past(occ))); // R7

    AST_NO_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !err_o); // R11

endmodule

bind dq_delay_queue dq_delay_queue_chk #(.SLOTS(SLOTS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enq_valid_i (enq_valid_i),
    .tick_i      (tick_i),
    .full_o      (full_o),
    .occ         (occ),
    .rd_addr_i   (rd_addr_i),
    .rd_data_o   (rd_data_o),
    .err_o       (err_o)
);

// File: tb/tb_dq_delay_queue.sv
`timescale 1ns/1ps
module tb_dq_delay_queue;

    localparam int SLOTS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enq_valid_i = 1'b0;
    logic [1:0]  enq_reg_i = '0;
    logic [3:0]  enq_delay_i = '0;
    logic        enq_wide_i = 1'b0;
    logic        enq_bit_en_i = 1'b0;
    logic [5:0]  enq_bit_i = '0;
    logic [63:0] enq_value_i = '0;
    logic        tick_i = 1'b0;
    logic        full_o;
    logic [1:0]  rd_addr_i = '0;
    logic [63:0] rd_data_o;
    logic        err_o;

    int n_chk = 0;
    int n_bad = 0;

    dq_delay_queue #(.SLOTS(SLOTS)) dut (.*);

    always #2.5 clk = ~clk;

    typedef struct packed {
        logic [1:0]  r;
        logic        wide;
        logic        ben;
        logic [5:0]  pos;
        logic [63:0] val;
        logic [3:0]  dly;
        logic [63:0] exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 1'b1, 1'b0, 6'd0,  64'h1122334455667788, 4'd3,  64'h1122334455667788}, // R5 wide
        '{2'd0, 1'b0, 1'b0, 6'd0,  64'hFFFFFFFFAABBCCDD, 4'd2,  64'h11223344AABBCCDD}, // R5 narrow
        '{2'd1, 1'b1, 1'b1, 6'd40, 64'h1,                4'd1,  64'h0000010000000000}, // R6 set
        '{2'd1, 1'b0, 1'b1, 6'd37, 64'h5,                4'd0,  64'h0000010000000020}, // R6 pos low bits, R4 dly 0
        '{2'd1, 1'b1, 1'b1, 6'd40, 64'h0,                4'd4,  64'h0000000000000020}, // R6 clear
        '{2'd0, 1'b1, 1'b1, 6'd4,  64'h0,                4'd15, 64'h11223344AABBCCCD}, // R6 clear, R4 max
        '{2'd2, 1'b1, 1'b0, 6'd0,  64'hFFFFFFFFFFFFFFFF, 4'd2,  64'hFFFFFFFFFFFFFFFF}, // R5
        '{2'd2, 1'b0, 1'b1, 6'd31, 64'h0000000100000000, 4'd1,  64'hFFFFFFFF7FFFFFFF}  // R6 narrow zero test
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [63:0] v);
        rd_addr_i = a;
        #0.5;
        v = rd_data_o;
    endtask

    task automatic push(input logic [1:0] r, input logic w, input logic b, input logic [5:0] p,
                        input logic [63:0] v, input logic [3:0] dl, input logic t);
        @(negedge clk);
        enq_valid_i = 1'b1; enq_reg_i = r; enq_wide_i = w; enq_bit_en_i = b;
        enq_bit_i = p; enq_value_i = v; enq_delay_i = dl; tick_i = t;
        @(posedge clk);
        #1;
        enq_valid_i = 1'b0; tick_i = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_i = 1'b1;
            @(posedge clk);
            #1;
            tick_i = 1'b0;
        end
    endtask

    bit finished = 0;

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] v, prior;
        int nt;
        #12;
        rst_n = 1'b1;
        #3;
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R1 reg", v, 64'h0);
        end
        check("R1 full", {63'b0, full_o}, 64'h0);
        check("R1 err", {63'b0, err_o}, 64'h0);

        // Vector table
        for (int i = 0; i < 8; i++) begin
            rd(VECS[i].r, prior);
            push(VECS[i].r, VECS[i].wide, VECS[i].ben, VECS[i].pos, VECS[i].val, VECS[i].dly, 1'b0);
            nt = (VECS[i].dly == 0) ? 1 : int'(VECS[i].dly);
            tick(nt - 1);
            rd(VECS[i].r, v);
            check("R4 not before expiry", v, prior);
            tick(1);
            rd(VECS[i].r, v);
            check("R4/R5/R6 write on expiry", v, VECS[i].exp);
        end

        // R10-like idle: ticks on empty queue change nothing
        tick(3);
        rd(2'd0, v);
        check("R4 empty ticks", v, 64'h11223344AABBCCCD);

        // R2/R3/R7 fill ring: long head then short followers
        push(2'd2, 1'b1, 1'b0, 6'd0, 64'h5A, 4'd6, 1'b0);
        for (int k = 0; k < 7; k++)
            push(2'd3, 1'b1, 1'b1, 6'(k), 64'h1, 4'd1, 1'b0);
        check("R2 full after SLOTS", {63'b0, full_o}, 64'h1);
        push(2'd3, 1'b1, 1'b0, 6'd0, 64'hDEAD, 4'd1, 1'b0);
        tick(1);
        rd(2'd3, v);
        check("R7 early followers", v, 64'h7F);
        check("R7 slots held", {63'b0, full_o}, 64'h1);
        tick(4);
        rd(2'd3, v);
        check("R3 dropped enqueue", v, 64'h7F);
        rd(2'd2, v);
        check("R7 head pending", v, 64'hFFFFFFFF7FFFFFFF);
        tick(1);
        rd(2'd2, v);
        check("R7 head write", v, 64'h5A);
        check("R7 ring released", {63'b0, full_o}, 64'h0);
        tick(5);
        rd(2'd3, v);
        check("R8 no repeat", v, 64'h7F);

        // R9 same-tick completions in queue order
        push(2'd0, 1'b1, 1'b0, 6'd0, 64'h111, 4'd2, 1'b0);
        push(2'd0, 1'b1, 1'b0, 6'd0, 64'h222, 4'd2, 1'b0);
        tick(2);
        rd(2'd0, v);
        check("R9 newest wins", v, 64'h222);

        // R10 enqueue coinciding with a tick
        push(2'd1, 1'b1, 1'b0, 6'd0, 64'h33, 4'd1, 1'b1);
        rd(2'd1, v);
        check("R10 not counted", v, 64'h20);
        tick(1);
        rd(2'd1, v);
        check("R10 next tick", v, 64'h33);

        // R8 completed follower behind head is not reapplied
        push(2'd1, 1'b1, 1'b0, 6'd0, 64'h44, 4'd3, 1'b0);
        push(2'd1, 1'b1, 1'b0, 6'd0, 64'h55, 4'd1, 1'b0);
        tick(1);
        rd(2'd1, v);
        check("R8 follower first", v, 64'h55);
        tick(2);
        rd(2'd1, v);
        check("R8 head later", v, 64'h44);
        tick(16);
        rd(2'd1, v);
        check("R8 exactly once", v, 64'h44);

        check("R11 err clear", {63'b0, err_o}, 64'h0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule